// File: doc/BRIEF.md
# Flash Status Auto-Polling Engine

This block keeps asking a serial flash for its status byte until that byte shows the state software is waiting for. A typical case is the end of a program or erase, when the write-in-progress bit clears. Each poll is one short transaction on four data lines. Chip select goes low, and two instruction nibbles are driven with the high nibble first. Then two status nibbles are read back, also high nibble first, with no dummy cycles between the phases. The received byte is masked and compared with a match value. Between polls chip select stays high for a programmed number of serial clock periods.

The hardware has no timeout and no poll counter. A run ends only in one of two ways: a match while auto-stop is set, or an abort strobe. With auto-stop clear, the engine polls forever and sets the sticky match flag on every hit. A done flag records that a run has really ended, so software can confirm the stop after either exit. An interrupt output mirrors the match flag when it is enabled.

The block has no data stream to hand off. Configuration, strobes and flags are plain level or single-cycle pins, so no valid/ready handshake and no back-pressure apply. The serial clock runs at half the system clock.

Top module: `ap_status_poller`

## Requirements
- R1: After reset, `cs_n`=1, `sck`=0, `q_oe`=0, and `busy`, `match_flag`, `done_flag` and `irq` are all 0.
- R2: Each poll sets `cs_n`=0 and then gives four `sck` pulses. Each pulse is one system clock low followed by one system clock high. On the first two pulses `q_oe`=1 and `q_out` carries `cfg_opcode`, bits [7:4] then bits [3:0]. On the last two pulses `q_oe`=0, and `q_in` is sampled at the end of each high phase, giving bits [7:4] then bits [3:0].
- R3: When `cfg_or_mode`=0, a byte hits when every bit with `cfg_mask`=1 equals the same bit of `cfg_match`. With a zero mask, every byte hits.
- R4: When `cfg_or_mode`=1, a byte hits when at least one bit with `cfg_mask`=1 equals the same bit of `cfg_match`. With a zero mask, no byte hits.
- R5: Between two polls `cs_n` stays high for 2·N system clocks, where N = `cfg_interval`. A value of 0 is treated as 1.
- R6: With `cfg_auto_stop`=1, a hit ends the run. `busy` drops, `cs_n` stays high, and `match_flag` and `done_flag` are set on the clock after the last data sample.
- R7: With `cfg_auto_stop`=0, polling continues after a hit. `match_flag` is set and stays set, and `busy` stays 1.
- R8: `match_flag` stays set until a `clr_match` pulse arrives in a cycle with no new hit. `irq` = `match_flag` AND `cfg_irq_en`.
- R9: An `abort` while `busy`=1 brings `cs_n` to 1, `sck` to 0 and `busy` to 0 on the next clock, and sets `done_flag`. An abort while idle has no effect.
- R10: An `abort` in the same cycle as the last data sample wins. The byte is dropped, `match_flag` is not set, and the run ends.
- R11: `start` begins a run only from idle and only if `abort` is low in that cycle.
- R12: `done_flag` stays set until a `clr_done` pulse arrives.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_opcode | input | 8 | Status-read instruction byte |
| cfg_mask | input | 8 | Bits of the status byte taking part in the compare |
| cfg_match | input | 8 | Value compared with the masked status bits |
| cfg_interval | input | 16 | Gap between polls in serial clock periods |
| cfg_or_mode | input | 1 | 1 = any selected bit matches, 0 = all selected bits match |
| cfg_auto_stop | input | 1 | End the run on the first hit |
| cfg_irq_en | input | 1 | Let the match flag drive `irq` |
| start | input | 1 | Single-cycle run request |
| abort | input | 1 | Single-cycle stop request |
| clr_match | input | 1 | Clear the match flag |
| clr_done | input | 1 | Clear the done flag |
| q_in | input | 4 | Data lines from the flash |
| q_out | output | 4 | Data lines to the flash |
| q_oe | output | 1 | Output enable for `q_out` |
| cs_n | output | 1 | Chip select, active low |
| sck | output | 1 | Serial clock |
| busy | output | 1 | A run is in progress |
| match_flag | output | 1 | Sticky hit flag |
| done_flag | output | 1 | Sticky flag: run ended by hit or abort |
| irq | output | 1 | Match interrupt |

## Verification
The two functions that can fall in the same cycle are the abort and the capture of the last status nibble, which is also the cycle that decides a hit. The bench returns a byte that would match. It then raises abort so that it is sampled on exactly the clock edge that completes the byte, counting eight clocks from the start strobe. Afterwards the match flag must still be clear, busy must be low and the done flag must be set, which shows that the abort won and no partial or cut-off byte was judged.

// File: rtl/ap_pkg.sv
package ap_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_CMD  = 2'd1,
    ST_DATA = 2'd2,
    ST_GAP  = 2'd3
  } ap_state_e;
endpackage

// File: rtl/ap_compare.sv
// Masked status comparison: all-selected-bits or any-selected-bit.
module ap_compare #(
  parameter int DW = 8
) (
  input  logic [DW-1:0] status_i,
  input  logic [DW-1:0] mask_i,
  input  logic [DW-1:0] match_i,
  input  logic          or_mode_i,
  output logic          hit_o
);
  logic [DW-1:0] agree;
  logic          all_ok;
  logic          any_ok;

  generate
    for (genvar b = 0; b < DW; b++) begin : g_bit
      assign agree[b] = ~(status_i[b] ^ match_i[b]);
    end
  endgenerate

  assign all_ok = &(agree | ~mask_i);
  assign any_ok = |(agree & mask_i);
  assign hit_o  = or_mode_i ? any_ok : all_ok;
endmodule

// File: rtl/ap_shifter.sv
// Drives instruction nibbles (high first) and assembles the status byte.
module ap_shifter #(
  parameter int DW    = 8,
  parameter int LANES = 4,
  parameter int NIB   = 2,
  parameter int CW    = 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [DW-1:0]    opcode_i,
  input  logic [CW-1:0]    nib_i,
  input  logic             cap_i,
  input  logic [LANES-1:0] q_in_i,
  output logic [LANES-1:0] q_out_o,
  output logic [DW-1:0]    byte_o
);
  logic [LANES-1:0] onib [NIB];
  logic [DW-1:0]    sh;

  generate
    for (genvar k = 0; k < NIB; k++) begin : g_nib
      assign onib[k] = opcode_i[DW-1-k*LANES -: LANES];
    end
  endgenerate

  assign q_out_o = onib[nib_i];

  always_ff @(posedge clk) begin
    if (!rst_n)     sh <= '0;
    else if (cap_i) sh <= {sh[DW-LANES-1:0], q_in_i};
  end

  // full byte is formed with the nibble present on the final sample edge
  assign byte_o = {sh[DW-LANES-1:0], q_in_i};
endmodule

// File: rtl/ap_interval.sv
// Counts the chip-select-high gap: 2 system clocks per serial period.
module ap_interval #(
  parameter int IW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load_i,
  input  logic          run_i,
  input  logic [IW-1:0] interval_i,
  output logic          expire_o
);
  localparam int CW = IW + 2;
  logic [CW-1:0] cnt;
  logic [CW-1:0] limit;

  assign limit = (interval_i == '0) ? CW'(2) : {1'b0, interval_i, 1'b0};

  always_ff @(posedge clk) begin
    if (!rst_n)      cnt <= '0;
    else if (load_i) cnt <= '0;
    else if (run_i)  cnt <= cnt + CW'(1);
  end

  assign expire_o = run_i && (cnt == limit - CW'(1));
endmodule

// File: rtl/ap_status_poller.sv
module ap_status_poller #(
  parameter int DW    = 8,
  parameter int LANES = 4,
  parameter int IW    = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [DW-1:0]    cfg_opcode,
  input  logic [DW-1:0]    cfg_mask,
  input  logic [DW-1:0]    cfg_match,
  input  logic [IW-1:0]    cfg_interval,
  input  logic             cfg_or_mode,
  input  logic             cfg_auto_stop,
  input  logic             cfg_irq_en,
  input  logic             start,
  input  logic             abort,
  input  logic             clr_match,
  input  logic             clr_done,
  input  logic [LANES-1:0] q_in,
  output logic [LANES-1:0] q_out,
  output logic             q_oe,
  output logic             cs_n,
  output logic             sck,
  output logic             busy,
  output logic             match_flag,
  output logic             done_flag,
  output logic             irq
);
  import ap_pkg::*;

  localparam int NIB = DW / LANES;
  localparam int CW  = (NIB > 1) ? $clog2(NIB) : 1;
  localparam logic [CW-1:0] LAST = CW'(NIB - 1);

  ap_state_e     st;
  logic          ph;
  logic [CW-1:0] nib;
  logic          match_q;
  logic          done_q;

  logic          active;
  logic          last_edge;
  logic          hit_raw;
  logic          hit;
  logic          stop_hit;
  logic          kill;
  logic          done_set;
  logic          gap_load;
  logic          gap_expire;
  logic          cap;
  logic [DW-1:0] rx_byte;

  assign active    = (st == ST_CMD) || (st == ST_DATA);
  assign last_edge = (st == ST_DATA) && ph && (nib == LAST);
  assign hit       = last_edge && hit_raw;
  assign stop_hit  = hit && cfg_auto_stop;
  assign kill      = abort && (st != ST_IDLE);
  assign done_set  = kill || (stop_hit && !abort);
  assign gap_load  = last_edge && !stop_hit && !abort;
  assign cap       = (st == ST_DATA) && ph;

  ap_shifter #(.DW(DW), .LANES(LANES), .NIB(NIB), .CW(CW)) u_shift (
    .clk      (clk),
    .rst_n    (rst_n),
    .opcode_i (cfg_opcode),
    .nib_i    (nib),
    .cap_i    (cap),
    .q_in_i   (q_in),
    .q_out_o  (q_out),
    .byte_o   (rx_byte)
  );

  ap_compare #(.DW(DW)) u_cmp (
    .status_i  (rx_byte),
    .mask_i    (cfg_mask),
    .match_i   (cfg_match),
    .or_mode_i (cfg_or_mode),
    .hit_o     (hit_raw)
  );

  ap_interval #(.IW(IW)) u_gap (
    .clk        (clk),
    .rst_n      (rst_n),
    .load_i     (gap_load),
    .run_i      (st == ST_GAP),
    .interval_i (cfg_interval),
    .expire_o   (gap_expire)
  );

  // sequencer
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st  <= ST_IDLE;
      ph  <= 1'b0;
      nib <= '0;
    end else if (kill) begin
      st  <= ST_IDLE;
      ph  <= 1'b0;
      nib <= '0;
    end else begin
      unique case (st)
        ST_IDLE: begin
          if (start && !abort) begin
            st  <= ST_CMD;
            ph  <= 1'b0;
            nib <= '0;
          end
        end
        ST_CMD: begin
          ph <= ~ph;
          if (ph) begin
            if (nib == LAST) begin
              st  <= ST_DATA;
              nib <= '0;
            end else begin
              nib <= nib + CW'(1);
            end
          end
        end
        ST_DATA: begin
          ph <= ~ph;
          if (ph) begin
            if (nib == LAST) begin
              st  <= stop_hit ? ST_IDLE : ST_GAP;
              nib <= '0;
            end else begin
              nib <= nib + CW'(1);
            end
          end
        end
        ST_GAP: begin
          if (gap_expire) begin
            st <= ST_CMD;
            ph <= 1'b0;
          end
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  // sticky flags: a set in the same cycle as a clear wins
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      match_q <= 1'b0;
      done_q  <= 1'b0;
    end else begin
      if (hit && !abort) match_q <= 1'b1;
      else if (clr_match) match_q <= 1'b0;
      if (done_set)      done_q <= 1'b1;
      else if (clr_done) done_q <= 1'b0;
    end
  end

  assign cs_n       = ~active;
  assign sck        = active && ph;
  assign q_oe       = (st == ST_CMD);
  assign busy       = (st != ST_IDLE);
  assign match_flag = match_q;
  assign done_flag  = done_q;
  assign irq        = match_q && cfg_irq_en;

  // R9
  abort_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy && abort |=> !busy && cs_n && !sck && done_flag);

  // R10
  abort_beats_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
    abort && !match_flag |=> !match_flag);

  // R6
  auto_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hit && cfg_auto_stop && !abort |=> !busy && cs_n && done_flag && match_flag);

  // R8
  clr_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr_match && !hit |=> !match_flag);

  // R5
  gap_min_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cs_n) && busy |=> cs_n);

  // R11
  idle_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy && start && !abort |=> busy && !cs_n);
endmodule

// File: tb/tb_ap_status_poller.sv
module tb_ap_status_poller;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] cfg_opcode = 8'h05, cfg_mask = 8'h01, cfg_match = 8'h00;
  logic [15:0] cfg_interval = 16'd1;
  logic       cfg_or_mode = 1'b0, cfg_auto_stop = 1'b1, cfg_irq_en = 1'b0;
  logic       start = 1'b0, abort = 1'b0, clr_match = 1'b0, clr_done = 1'b0;
  logic [3:0] q_in = 4'h0;
  logic [3:0] q_out;
  logic       q_oe, cs_n, sck, busy, match_flag, done_flag, irq;

  always #10 clk = ~clk;

  ap_status_poller dut (
    .clk(clk), .rst_n(rst_n), .cfg_opcode(cfg_opcode), .cfg_mask(cfg_mask),
    .cfg_match(cfg_match), .cfg_interval(cfg_interval), .cfg_or_mode(cfg_or_mode),
    .cfg_auto_stop(cfg_auto_stop), .cfg_irq_en(cfg_irq_en), .start(start),
    .abort(abort), .clr_match(clr_match), .clr_done(clr_done), .q_in(q_in),
    .q_out(q_out), .q_oe(q_oe), .cs_n(cs_n), .sck(sck), .busy(busy),
    .match_flag(match_flag), .done_flag(done_flag), .irq(irq)
  );

  int n_chk = 0;
  int n_bad = 0;
  bit finished = 0;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // flash model: returns queued status bytes, records instruction nibbles
  logic [7:0] resp_q[$];
  logic [7:0] cur = 8'h00;
  logic [7:0] cmd_rx = 8'h00;
  int         rises = 0;
  int         oe_err = 0;

  always @(negedge cs_n) begin
    rises = 0;
    oe_err = 0;
    if (resp_q.size() > 0) cur = resp_q.pop_front();
  end

  always @(posedge sck) begin
    rises++;
    if (rises <= 2) begin
      cmd_rx = {cmd_rx[3:0], q_out};
      if (!q_oe) oe_err++;
    end else if (q_oe) oe_err++;
    if (rises == 3) q_in = cur[7:4];
    if (rises == 4) q_in = cur[3:0];
  end

  // scoreboard: expected outcome of each completed poll
  typedef struct packed { logic m; logic b; } item_t;
  item_t exp_q[$];
  int    exp_gap = 0;
  bit    gap_armed = 0;
  time   t_rise = 0;

  always @(posedge cs_n) begin
    int r;
    item_t it;
    r = rises;
    t_rise = $time;
    @(negedge clk);
    if (r == 4 && exp_q.size() > 0) begin
      it = exp_q.pop_front();
      chk("R2 opcode nibbles", {24'h0, cmd_rx}, {24'h0, cfg_opcode});
      chk("R2 q_oe phases", oe_err, 0);
      chk("R3/R4/R7/R10 match_flag after poll", {31'h0, match_flag}, {31'h0, it.m});
      chk("R6/R7 busy after poll", {31'h0, busy}, {31'h0, it.b});
      gap_armed = busy;
    end
  end

  always @(negedge cs_n) begin
    if (gap_armed && exp_gap > 0)
      chk("R5 cs_n high gap", 32'(($time - t_rise) / 20), 32'(exp_gap));
    gap_armed = 0;
  end

  task automatic push(input logic [7:0] b, input logic m, input logic bz);
    item_t it;
    resp_q.push_back(b);
    it.m = m; it.b = bz;
    exp_q.push_back(it);
  endtask

  task automatic start_poll();
    gap_armed = 0;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic wait_idle(input string tag);
    int k = 0;
    while (busy && k < 5000) begin @(negedge clk); k++; end
    @(negedge clk);
    chk(tag, {31'h0, busy}, 32'h0);
  endtask

  task automatic wait_drain(input string tag);
    int k = 0;
    while (exp_q.size() > 0 && k < 5000) begin @(negedge clk); k++; end
    chk(tag, exp_q.size(), 0);
  endtask

  task automatic clear_flags();
    clr_match = 1'b1; clr_done = 1'b1;
    @(negedge clk);
    clr_match = 1'b0; clr_done = 1'b0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_bad++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 cs_n", {31'h0, cs_n}, 32'h1);
    chk("R1 sck", {31'h0, sck}, 32'h0);
    chk("R1 q_oe", {31'h0, q_oe}, 32'h0);
    chk("R1 flags", {28'h0, busy, match_flag, done_flag, irq}, 32'h0);

    // AND mode, auto-stop, WIP bit; R3 R5 R6 R8
    cfg_opcode = 8'h05; cfg_mask = 8'h01; cfg_match = 8'h00;
    cfg_or_mode = 0; cfg_auto_stop = 1; cfg_irq_en = 1; cfg_interval = 16'd3;
    exp_gap = 6;
    push(8'h03, 0, 1); push(8'h03, 0, 1); push(8'h02, 1, 0);
    start_poll();
    wait_idle("R6 run ends on hit");
    wait_drain("R6 all polls seen");
    chk("R6 done_flag", {31'h0, done_flag}, 32'h1);
    chk("R8 irq follows flag", {31'h0, irq}, 32'h1);
    repeat (3) @(negedge clk);
    chk("R6 cs_n stays high", {31'h0, cs_n}, 32'h1);

    // R8 / R12 clears
    clr_match = 1; @(negedge clk); clr_match = 0;
    chk("R8 clr_match", {30'h0, match_flag, irq}, 32'h0);
    chk("R12 done held", {31'h0, done_flag}, 32'h1);
    clr_done = 1; @(negedge clk); clr_done = 0;
    chk("R12 clr_done", {31'h0, done_flag}, 32'h0);

    // OR mode, other opcode; R4 R2 R8 (irq disabled)
    cfg_opcode = 8'h9C; cfg_mask = 8'hF0; cfg_match = 8'hA0;
    cfg_or_mode = 1; cfg_irq_en = 0; cfg_interval = 16'd2; exp_gap = 4;
    push(8'h5F, 0, 1); push(8'h1F, 1, 0);
    start_poll();
    wait_idle("R4 run ends");
    wait_drain("R4 all polls seen");
    chk("R8 irq masked", {30'h0, match_flag, irq}, 32'h2);
    clear_flags();

    // AND mode with same mask; R3
    cfg_or_mode = 0; cfg_opcode = 8'h05;
    push(8'h1F, 0, 1); push(8'hA5, 1, 0);
    start_poll();
    wait_idle("R3 run ends");
    wait_drain("R3 all polls seen");
    clear_flags();

    // AND mode zero mask hits at once; R3
    cfg_mask = 8'h00;
    push(8'h77, 1, 0);
    start_poll();
    wait_idle("R3 zero mask run ends");
    wait_drain("R3 zero mask poll seen");
    clear_flags();

    // OR mode zero mask never hits; R4
    cfg_or_mode = 1; cfg_auto_stop = 1;
    push(8'hA0, 0, 1);
    start_poll();
    wait_drain("R4 zero mask poll seen");
    chk("R4 zero mask still busy", {31'h0, busy}, 32'h1);
    abort = 1; @(negedge clk); abort = 0;
    chk("R9 abort stops run", {30'h0, busy, cs_n}, 32'h1);
    clear_flags();

    // no auto-stop, interval 0 -> min gap; R7 R5 R9
    cfg_or_mode = 0; cfg_mask = 8'h01; cfg_match = 8'h00;
    cfg_auto_stop = 0; cfg_interval = 16'd0; exp_gap = 2;
    push(8'h03, 0, 1); push(8'h02, 1, 1); push(8'h03, 1, 1); push(8'h02, 1, 1);
    start_poll();
    wait_drain("R7 polls continue");
    chk("R7 still busy after hits", {31'h0, busy}, 32'h1);
    abort = 1; @(negedge clk); abort = 0;
    chk("R9 busy low after abort", {31'h0, busy}, 32'h0);
    chk("R9 cs_n/sck idle", {30'h0, cs_n, sck}, 32'h2);
    chk("R9 done set", {31'h0, done_flag}, 32'h1);
    chk("R7 match kept", {31'h0, match_flag}, 32'h1);
    clear_flags();

    // abort during instruction phase; R9
    cfg_auto_stop = 1; exp_gap = 0;
    resp_q.push_back(8'h00);
    start_poll();
    @(negedge clk);
    abort = 1; @(negedge clk); abort = 0;
    chk("R9 mid-instruction cs_n", {31'h0, cs_n}, 32'h1);
    chk("R9 mid-instruction busy/match/done", {29'h0, busy, match_flag, done_flag}, 32'h1);
    clear_flags();

    // abort on the final sample edge of a matching byte; R10
    push(8'h00, 0, 0);
    start_poll();
    repeat (7) @(negedge clk);
    abort = 1; @(negedge clk); abort = 0;
    chk("R10 no match on cut byte", {31'h0, match_flag}, 32'h0);
    chk("R10 run ended", {30'h0, busy, done_flag}, 32'h1);
    wait_drain("R10 poll seen");
    clear_flags();

    // start together with abort in idle, abort alone in idle; R11 R9
    start = 1; abort = 1; @(negedge clk); start = 0; abort = 0;
    repeat (3) @(negedge clk);
    chk("R11 start+abort ignored", {30'h0, busy, cs_n}, 32'h1);
    abort = 1; @(negedge clk); abort = 0;
    chk("R9 idle abort no done", {31'h0, done_flag}, 32'h0);

    // engine still usable afterwards; R11
    push(8'h00, 1, 0);
    start_poll();
    chk("R11 start from idle", {30'h0, busy, cs_n}, 32'h2);
    wait_idle("R11 run ends");
    wait_drain("R11 poll seen");

    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule